// File: doc/BRIEF.md
# Region-Programmed Bus Cycle Timer

This block times the external bus cycles of a processor with a 24-bit address. The top three address bits pick one of eight 2 MB regions. Each region has two settings of its own:

- a type bit, which chooses a short access of two clocks or a long access of at least three clocks;
- an enable bit, which allows wait clocks to be added to a long access.

A single 2-bit count, shared by all regions, gives the number of wait clocks.

A request is taken while the block is idle, or in the last clock of the access in progress. The block then steps through its phase strobes: first, second, any waits, and, for a long access, a closing phase. It raises a one-clock done pulse in the final clock of the access.

The three settings are loaded through separate write strobes. Each access takes a snapshot of its settings when the request is taken, so later writes only change later accesses. Chip-select decoding and data steering are handled elsewhere.

Top module: `bus_wait_ctl`

## Requirements
- R1: The region index is address bits 23:21, so region k covers byte addresses k*0x200000 up to k*0x200000+0x1FFFFF.
- R2: When the type bit of the addressed region is 0, the access is short. It lasts exactly 2 clocks (first, then second phase), with no wait strobe, whatever the enable bit and count hold.
- R3: When the type bit is 1 and the enable bit is 0, the access lasts exactly 3 clocks (first, second, closing phase), even when the count is nonzero.
- R4: When the type bit and the enable bit are both 1, the access lasts 3 plus the count clocks. The wait strobe is high for exactly the count clocks, between the second and closing phases.
- R5: After reset, every type bit is 1, every enable bit is 1 and the count is 3. While reset is held, all strobes and done are low.
- R6: A request is taken at a clock edge when the block is idle or done is high. The first-phase strobe is then high in the next clock. Done is high for one clock only, in the final clock of the access.
- R7: A request that is present while an access runs and done is low is ignored. It starts no access.
- R8: A write to any of the three settings that arrives after a request was taken does not change the timing of that access. It does apply to the accesses taken after the write.
- R9: While busy, exactly one of the four phase strobes is high. While idle, none is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_i | input | 1 | Bus cycle request |
| addr_i | input | 24 | Address of the request |
| type_we_i | input | 1 | Write strobe for the type bits |
| type_i | input | 8 | Type bits, bit k for region k (1 = long access) |
| wen_we_i | input | 1 | Write strobe for the enable bits |
| wen_i | input | 8 | Enable bits, bit k for region k |
| cnt_we_i | input | 1 | Write strobe for the shared count |
| cnt_i | input | 2 | Wait count |
| busy_o | output | 1 | An access is in progress |
| ph1_o | output | 1 | First-phase strobe |
| ph2_o | output | 1 | Second-phase strobe |
| phw_o | output | 1 | Wait-phase strobe |
| ph3_o | output | 1 | Closing-phase strobe of a long access |
| done_o | output | 1 | Final clock of the access |

## Verification
Two events can fall in the same clock edge.

The first pair is the end of one access and the start of the next. The bench raises a new request in exactly the clock where done is seen high. It then requires the first-phase strobe in the very next clock, and it requires each access to keep its own length.

The second pair is a settings write and an access already under way. The bench changes the count, the enables and the types while a long access runs. It requires that access to keep its old length and the next access to follow the new settings.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_ONE  = 3'd1,
      PH_TWO  = 3'd2,
      PH_WAIT = 3'd3,
      PH_END  = 3'd4
   } phase_e;
endpackage

// File: rtl/wsc_cfg_regs.sv
module wsc_cfg_regs #(
   parameter int NREG    = 8,
   parameter int CNT_W   = 2,
   parameter bit RST_TYP = 1'b1,
   parameter bit RST_WEN = 1'b1,
   parameter int RST_CNT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             type_we,
   input  logic [NREG-1:0]  type_d,
   input  logic             wen_we,
   input  logic [NREG-1:0]  wen_d,
   input  logic             cnt_we,
   input  logic [CNT_W-1:0] cnt_d,
   output logic [NREG-1:0]  type_q,
   output logic [NREG-1:0]  wen_q,
   output logic [CNT_W-1:0] cnt_q
);
   localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(RST_CNT);

   for (genvar k = 0; k < NREG; k++) begin : g_region
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            type_q[k] <= RST_TYP;
            wen_q[k]  <= RST_WEN;
         end else begin
            if (type_we) type_q[k] <= type_d[k];
            if (wen_we)  wen_q[k]  <= wen_d[k];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= CNT_INIT;
      else if (cnt_we) cnt_q <= cnt_d;
   end
endmodule

// File: rtl/wsc_len_calc.sv
module wsc_len_calc #(
   parameter int ADDR_W      = 24,
   parameter int REGION_BITS = 3,
   parameter int CNT_W       = 2
) (
   input  logic [ADDR_W-1:0]          addr,
   input  logic [(1<<REGION_BITS)-1:0] type_q,
   input  logic [(1<<REGION_BITS)-1:0] wen_q,
   input  logic [CNT_W-1:0]           cnt_q,
   output logic                       long_acc,
   output logic [CNT_W-1:0]           waits
);
   logic [REGION_BITS-1:0] region;

   assign region   = addr[ADDR_W-1 -: REGION_BITS];
   assign long_acc = type_q[region];

   always_comb begin
      if (long_acc && wen_q[region]) waits = cnt_q;
      else                           waits = '0;
   end
endmodule

// File: rtl/wsc_seq.sv
module wsc_seq
   import wsc_pkg::*;
#(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             long_in,
   input  logic [CNT_W-1:0] waits_in,
   output logic             busy,
   output logic             ph1,
   output logic             ph2,
   output logic             phw,
   output logic             ph3,
   output logic             done
);
   localparam logic [CNT_W-1:0] ONE_LEFT = CNT_W'(1);

   phase_e           ph_q;
   logic             long_q;
   logic [CNT_W-1:0] left_q;
   logic             take;

   assign done = (ph_q == PH_END) || ((ph_q == PH_TWO) && !long_q);
   assign take = req && ((ph_q == PH_IDLE) || done);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         long_q <= 1'b0;
         left_q <= '0;
      end else if (take) begin
         ph_q   <= PH_ONE;
         long_q <= long_in;
         left_q <= waits_in;
      end else begin
         unique case (ph_q)
            PH_ONE:  ph_q <= PH_TWO;
            PH_TWO: begin
               if (!long_q)          ph_q <= PH_IDLE;
               else if (left_q != 0) ph_q <= PH_WAIT;
               else                  ph_q <= PH_END;
            end
            PH_WAIT: begin
               left_q <= left_q - ONE_LEFT;
               if (left_q == ONE_LEFT) ph_q <= PH_END;
            end
            PH_END:  ph_q <= PH_IDLE;
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign busy = (ph_q != PH_IDLE);
   assign ph1  = (ph_q == PH_ONE);
   assign ph2  = (ph_q == PH_TWO);
   assign phw  = (ph_q == PH_WAIT);
   assign ph3  = (ph_q == PH_END);
endmodule

// File: rtl/bus_wait_ctl.sv
module bus_wait_ctl #(
   parameter int ADDR_W      = 24,
   parameter int REGION_BITS = 3,
   parameter int CNT_W       = 2,
   parameter bit RST_TYP     = 1'b1,
   parameter bit RST_WEN     = 1'b1,
   parameter int RST_CNT     = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_i,
   input  logic [ADDR_W-1:0]           addr_i,
   input  logic                        type_we_i,
   input  logic [(1<<REGION_BITS)-1:0] type_i,
   input  logic                        wen_we_i,
   input  logic [(1<<REGION_BITS)-1:0] wen_i,
   input  logic                        cnt_we_i,
   input  logic [CNT_W-1:0]            cnt_i,
   output logic                        busy_o,
   output logic                        ph1_o,
   output logic                        ph2_o,
   output logic                        phw_o,
   output logic                        ph3_o,
   output logic                        done_o
);
   localparam int NREG = 1 << REGION_BITS;

   if (REGION_BITS < 1 || REGION_BITS > ADDR_W) begin : g_bad_regions
      $error("bus_wait_ctl: REGION_BITS must lie in 1..ADDR_W");
   end
   if (CNT_W < 1 || RST_CNT < 0 || RST_CNT >= (1 << CNT_W)) begin : g_bad_count
      $error("bus_wait_ctl: RST_CNT must fit in CNT_W bits");
   end

   logic [NREG-1:0]  type_q;
   logic [NREG-1:0]  wen_q;
   logic [CNT_W-1:0] cnt_q;
   logic             long_acc;
   logic [CNT_W-1:0] waits;

   wsc_cfg_regs #(
      .NREG(NREG), .CNT_W(CNT_W),
      .RST_TYP(RST_TYP), .RST_WEN(RST_WEN), .RST_CNT(RST_CNT)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .type_we(type_we_i), .type_d(type_i),
      .wen_we(wen_we_i), .wen_d(wen_i),
      .cnt_we(cnt_we_i), .cnt_d(cnt_i),
      .type_q(type_q), .wen_q(wen_q), .cnt_q(cnt_q)
   );

   wsc_len_calc #(
      .ADDR_W(ADDR_W), .REGION_BITS(REGION_BITS), .CNT_W(CNT_W)
   ) u_len (
      .addr(addr_i), .type_q(type_q), .wen_q(wen_q), .cnt_q(cnt_q),
      .long_acc(long_acc), .waits(waits)
   );

   wsc_seq #(.CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .req(req_i),
      .long_in(long_acc), .waits_in(waits),
      .busy(busy_o), .ph1(ph1_o), .ph2(ph2_o), .phw(phw_o),
      .ph3(ph3_o), .done(done_o)
   );
endmodule

// File: rtl/wsc_chk.sv
module wsc_chk #(
   parameter int CNT_W = 2
) (
   input logic clk,
   input logic rst_n,
   input logic req_i,
   input logic busy_o,
   input logic ph1_o,
   input logic ph2_o,
   input logic phw_o,
   input logic ph3_o,
   input logic done_o
);
   localparam int MAXW = (1 << CNT_W) - 1;

   logic [CNT_W:0] wrun;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     wrun <= '0;
      else if (phw_o) wrun <= wrun + 1'b1;
      else            wrun <= '0;
   end

   // R9
   phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ph1_o, ph2_o, phw_o, ph3_o}) && (busy_o == |{ph1_o, ph2_o, phw_o, ph3_o}));
   // R6
   first_then_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph1_o |=> ph2_o);
   // R6
   done_in_last_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (ph2_o || ph3_o));
   // R6
   done_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && req_i) |=> ph1_o);
   // R6
   done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !req_i) |=> !busy_o);
   // R3
   long_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph2_o && !done_o) |=> (phw_o || ph3_o));
   // R4
   wait_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phw_o |=> (phw_o || ph3_o));
   // R4
   wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phw_o |-> (int'(wrun) < MAXW));
   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !req_i) |=> !busy_o);
   // R7
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> !ph1_o);
endmodule

bind bus_wait_ctl wsc_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_i(req_i), .busy_o(busy_o),
   .ph1_o(ph1_o), .ph2_o(ph2_o), .phw_o(phw_o), .ph3_o(ph3_o),
   .done_o(done_o)
);

// File: tb/bus_wait_ctl_bench.sv
`timescale 1ns/1ps
module bus_wait_ctl_bench;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n, req, type_we, wen_we, cnt_we;
   logic [23:0] addr;
   logic [7:0]  type_d, wen_d;
   logic [1:0]  cnt_d;
   logic        busy, ph1, ph2, phw, ph3, done;

   bus_wait_ctl u_bus_wait_ctl (
      .clk(clk), .rst_n(rst_n), .req_i(req), .addr_i(addr),
      .type_we_i(type_we), .type_i(type_d), .wen_we_i(wen_we), .wen_i(wen_d),
      .cnt_we_i(cnt_we), .cnt_i(cnt_d), .busy_o(busy), .ph1_o(ph1),
      .ph2_o(ph2), .phw_o(phw), .ph3_o(ph3), .done_o(done)
   );

   typedef struct { int len; int waits; string tag; } exp_t;
   exp_t q[$];

   logic [7:0] m_type = 8'hFF;
   logic [7:0] m_wen  = 8'hFF;
   int         m_cnt  = 3;
   int checks = 0, fails = 0;
   bit ended = 0;
   int cur_len = 0, cur_w = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // Settings write: driven at a negedge, taken at the following posedge
   task automatic wcfg(input int which, input logic [7:0] v);
      case (which)
         0: begin type_we = 1; type_d = v; end
         1: begin wen_we = 1; wen_d = v; end
         default: begin cnt_we = 1; cnt_d = v[1:0]; end
      endcase
      @(negedge clk);
      type_we = 0; wen_we = 0; cnt_we = 0;
      case (which)
         0: m_type = v;
         1: m_wen = v;
         default: m_cnt = int'(v[1:0]);
      endcase
   endtask

   // Driver: pushes the expected length, then presents the request
   task automatic issue(input logic [23:0] a, input string tag);
      exp_t e;
      int r;
      r = int'(a[23:21]);
      if (!m_type[r]) begin
         e.len = 2; e.waits = 0;
      end else begin
         e.waits = m_wen[r] ? m_cnt : 0;
         e.len = 3 + e.waits;
      end
      e.tag = tag;
      q.push_back(e);
      req = 1; addr = a;
      @(negedge clk);
      req = 0;
      chk(ph1 === 1'b1, "R6", "first phase after accept", int'(ph1), 1);
   endtask

   task automatic wait_ready();
      while (busy && !done) @(negedge clk);
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n === 1'b1 && !ended) begin
         chk(busy == ((ph1 + ph2 + phw + ph3) == 1) && (ph1 + ph2 + phw + ph3) <= 1,
             "R9", "strobe set", int'({ph1, ph2, phw, ph3}), int'(busy));
         if (ph1) begin
            cur_len = 1; cur_w = 0;
            if (q.size() == 0) chk(0, "R7", "unexpected access start", 1, 0);
         end else if (busy) begin
            cur_len++;
         end
         if (phw) cur_w++;
         if (done && q.size() != 0) begin
            exp_t e;
            e = q.pop_front();
            chk(cur_len == e.len, e.tag, "access length", cur_len, e.len);
            chk(cur_w == e.waits, e.tag, "wait count", cur_w, e.waits);
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         fails++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 0; req = 0; addr = '0;
      type_we = 0; wen_we = 0; cnt_we = 0;
      type_d = '0; wen_d = '0; cnt_d = '0;
      repeat (3) @(negedge clk);
      chk({busy, ph1, ph2, phw, ph3, done} == 6'b0, "R5", "outputs in reset",
          int'({busy, ph1, ph2, phw, ph3, done}), 0);
      rst_n = 1;
      @(negedge clk);
      // R5: reset settings give long access with 3 waits
      issue(24'h000000, "R5"); wait_idle();

      // R1 and R2: regions 0 and 7 long, others short
      wcfg(0, 8'b1000_0001);
      issue(24'h200000, "R2"); wait_idle();
      issue(24'hE00000, "R1"); wait_idle();
      issue(24'h1FFFFF, "R1"); wait_idle();
      issue(24'hDFFFFF, "R1"); wait_idle();

      // R3: enable cleared for region 7, count still 3
      wcfg(1, 8'h7F);
      issue(24'hFFFFFF, "R3"); wait_idle();

      // R4: every count on region 0
      for (int c = 0; c < 4; c++) begin
         wcfg(2, 8'(c));
         issue(24'h000010, "R4"); wait_idle();
      end

      // R6: back-to-back requests in the done clock
      issue(24'h200000, "R6"); wait_ready();
      issue(24'h000000, "R6"); wait_ready();
      issue(24'h400000, "R6"); wait_ready();
      issue(24'h1F0000, "R6"); wait_idle();

      // R8: writes during a long access
      issue(24'h000000, "R8");
      wcfg(2, 8'd0);
      wcfg(1, 8'h00);
      wcfg(0, 8'h00);
      wait_idle();
      issue(24'h000000, "R8"); wait_idle();

      // R7: request while busy and not done is ignored
      wcfg(0, 8'hFF); wcfg(1, 8'hFF); wcfg(2, 8'd3);
      issue(24'h000000, "R7");
      req = 1; addr = 24'h200000;
      @(negedge clk);
      req = 0;
      wait_idle();
      @(negedge clk);
      chk(busy == 1'b0, "R7", "busy after ignored request", int'(busy), 0);
      chk(q.size() == 0, "R7", "pending accesses", q.size(), 0);

      repeat (3) @(negedge clk);
      if (!ended) begin
         ended = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule